// File: doc/BRIEF.md
# Multi-channel input-capture timer

This block timestamps external events. A free-running up-counter serves as the timebase. Each of the capture channels watches its own input pin. When the pin shows the configured transition, the channel stores the current count in its own capture register and raises a sticky flag. Software reads the stored time and the flags over a simple register bus. It clears flags by writing ones, and it can route any flag to an interrupt line through a per-channel enable.

Each channel also has a mode bit that can hand the pin to a compare unit, which sits outside this block. While that bit is set, the channel is inert and never captures. The counter raises its own sticky overflow flag each time it wraps to zero, and that flag has its own interrupt enable.

The bus has a write strobe, an address and write data. Writes take effect at the next rising clock edge. Read data is a combinational function of the address.

Top module: `cap_timer`

## Requirements
- R1: After reset the counter reads 0 at address 0x0 and advances by one on every clock. A bus write to address 0x0 is ignored, so the count keeps running from its current value.
- R2: At the clock edge where the counter goes from 0xFFFF to 0x0000, the overflow flag (address 0x5, bit 0) becomes 1.
- R3: Writing 1 to bit 0 of address 0x5 clears the overflow flag. Writing 0 leaves it set. If the clear and a wrap fall on the same clock edge, the flag stays set.
- R4: The mode register (address 0x1, bit i for channel i) resets to 0, which selects capture. While bit i is 1, channel i never updates its capture register and never sets its flag.
- R5: The edge-select register (address 0x2) holds a 2-bit field for channel i at bits [2i+1:2i]. The codes are 00 = no capture, 01 = rising, 10 = falling and 11 = both.
- R6: Each pin passes through two synchronizing flops. The captured value equals the count read in the cycle during which the pin changed, plus 2.
- R7: A capture sets flag bit i at address 0x4. Writing 1 to a bit clears it and writing 0 has no effect. A capture on the same edge as the clear leaves the flag set.
- R8: A capture that arrives while the channel flag is still set overwrites the capture register with the newer count.
- R9: Capture register i reads at address 0x8+i and is read-only. Bus writes to it are ignored.
- R10: cap_irq[i] is high exactly when flag i and interrupt-enable bit i (address 0x3) are both set. ovf_irq is high exactly when the overflow flag and bit 0 of address 0x6 are both set.
- R11: After reset, the mode, edge-select, enable and flag registers, every capture register and both interrupt outputs all read zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cap_pin | input | NUM_CH | Event pins, one per channel, asynchronous to clk |
| bus_we | input | 1 | Register write strobe |
| bus_addr | input | 4 | Register address |
| bus_wdata | input | CNT_W | Register write data |
| bus_rdata | output | CNT_W | Register read data for bus_addr |
| cap_irq | output | NUM_CH | Per-channel capture interrupts |
| ovf_irq | output | 1 | Counter overflow interrupt |

## Verification
The bench drives a write-1 clear in exactly the cycle in which a capture, or the counter wrap, lands. A design that gave priority to the clear would lose that event and read back a zero flag. A second rising edge is sent while the flag is still pending; a design that froze the register on a set flag would keep returning the older timestamp. The bench also toggles the pin of a channel in compare mode and exercises each edge-select code. A design that ignored the mode bit, or swapped the rising and falling encodings, would raise flags or record times at the wrong transitions. Every stored time is compared against the count read when the pin moved plus the two synchronizer cycles, so any extra or missing flop in the pin path shows up.

// File: rtl/cap_timer_pkg.sv
package cap_timer_pkg;
    localparam int ADDR_W = 4;

    // register addresses
    localparam logic [ADDR_W-1:0] A_COUNT = 4'h0;
    localparam logic [ADDR_W-1:0] A_MODE  = 4'h1;
    localparam logic [ADDR_W-1:0] A_EDGE  = 4'h2;
    localparam logic [ADDR_W-1:0] A_IEN   = 4'h3;
    localparam logic [ADDR_W-1:0] A_CFLG  = 4'h4;
    localparam logic [ADDR_W-1:0] A_OFLG  = 4'h5;
    localparam logic [ADDR_W-1:0] A_OEN   = 4'h6;
    localparam logic [ADDR_W-1:0] A_CAP0  = 4'h8;

    // bit positions inside a channel's 2-bit edge field
    localparam int EDGE_RISE_BIT = 0;
    localparam int EDGE_FALL_BIT = 1;
endpackage

// File: rtl/cap_counter.sv
module cap_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    output logic [CNT_W-1:0] count_o,
    output logic             wrap_o
);
    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q + {{(CNT_W-1){1'b0}}, 1'b1};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cnt_q <= '0;
        else        cnt_q <= cnt_d;
    end

    assign count_o = cnt_q;
    // high in the cycle whose closing edge rolls the count to zero
    assign wrap_o  = &cnt_q;
endmodule

// File: rtl/cap_edge_det.sv
module cap_edge_det import cap_timer_pkg::*; #(
    parameter int NUM_CH = 8
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [NUM_CH-1:0]     pin_i,
    input  logic [2*NUM_CH-1:0]   sel_i,
    output logic [NUM_CH-1:0]     hit_o
);
    typedef struct packed {
        logic [NUM_CH-1:0] s1;
        logic [NUM_CH-1:0] s2;
        logic [NUM_CH-1:0] prev;
    } sync_t;

    sync_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.s1   = pin_i;
        st_d.s2   = st_q.s1;
        st_d.prev = st_q.s2;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic rise, fall;
        assign rise     = st_q.s2[g] & ~st_q.prev[g];
        assign fall     = ~st_q.s2[g] & st_q.prev[g];
        assign hit_o[g] = (sel_i[2*g+EDGE_RISE_BIT] & rise)
                        | (sel_i[2*g+EDGE_FALL_BIT] & fall);
    end
endmodule

// File: rtl/cap_timer.sv
module cap_timer import cap_timer_pkg::*; #(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] cap_pin,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [CNT_W-1:0]  bus_wdata,
    output logic [CNT_W-1:0]  bus_rdata,
    output logic [NUM_CH-1:0] cap_irq,
    output logic              ovf_irq
);
    typedef struct packed {
        logic [NUM_CH-1:0]            mode;
        logic [2*NUM_CH-1:0]          edge_sel;
        logic [NUM_CH-1:0]            irq_en;
        logic [NUM_CH-1:0]            cap_flag;
        logic                         ovf_flag;
        logic                         ovf_en;
        logic [NUM_CH-1:0][CNT_W-1:0] cap;
    } regs_t;

    regs_t             st_d, st_q;
    logic [CNT_W-1:0]  count;
    logic              wrap;
    logic [NUM_CH-1:0] hit;
    logic [NUM_CH-1:0] take;
    logic [NUM_CH-1:0] clr_cap;
    logic              clr_ovf;

    cap_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .count_o (count),
        .wrap_o  (wrap)
    );

    cap_edge_det #(.NUM_CH(NUM_CH)) u_edge (
        .clk   (clk),
        .rst_n (rst_n),
        .pin_i (cap_pin),
        .sel_i (st_q.edge_sel),
        .hit_o (hit)
    );

    // a channel owned by the compare side never captures
    assign take = hit & ~st_q.mode;

    always_comb begin
        st_d    = st_q;
        clr_cap = '0;
        clr_ovf = 1'b0;
        if (bus_we) begin
            case (bus_addr)
                A_MODE: st_d.mode     = bus_wdata[NUM_CH-1:0];
                A_EDGE: st_d.edge_sel = bus_wdata[2*NUM_CH-1:0];
                A_IEN:  st_d.irq_en   = bus_wdata[NUM_CH-1:0];
                A_CFLG: clr_cap       = bus_wdata[NUM_CH-1:0];
                A_OFLG: clr_ovf       = bus_wdata[0];
                A_OEN:  st_d.ovf_en   = bus_wdata[0];
                default: ;
            endcase
        end
        // new events take priority over a same-cycle clear
        st_d.cap_flag = (st_q.cap_flag & ~clr_cap) | take;
        st_d.ovf_flag = (st_q.ovf_flag & ~clr_ovf) | wrap;
        for (int i = 0; i < NUM_CH; i++) begin
            if (take[i]) st_d.cap[i] = count;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            A_COUNT: bus_rdata = count;
            A_MODE:  bus_rdata = CNT_W'(st_q.mode);
            A_EDGE:  bus_rdata = CNT_W'(st_q.edge_sel);
            A_IEN:   bus_rdata = CNT_W'(st_q.irq_en);
            A_CFLG:  bus_rdata = CNT_W'(st_q.cap_flag);
            A_OFLG:  bus_rdata = CNT_W'(st_q.ovf_flag);
            A_OEN:   bus_rdata = CNT_W'(st_q.ovf_en);
            default: begin
                for (int i = 0; i < NUM_CH; i++) begin
                    if (bus_addr == A_CAP0 + ADDR_W'(i)) bus_rdata = st_q.cap[i];
                end
            end
        endcase
    end

    assign cap_irq = st_q.cap_flag & st_q.irq_en;
    assign ovf_irq = st_q.ovf_flag & st_q.ovf_en;
endmodule

module cap_timer_chk import cap_timer_pkg::*; #(
    parameter int NUM_CH = 8,
    parameter int CNT_W  = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic [CNT_W-1:0]  count,
    input logic              ovf_flag,
    input logic [NUM_CH-1:0] cap_flag,
    input logic [NUM_CH-1:0] mode,
    input logic              bus_we,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [CNT_W-1:0]  bus_wdata
);
    logic [NUM_CH-1:0] clr_mask;
    logic              ovf_clr;

    assign clr_mask = (bus_we && bus_addr == A_CFLG) ? bus_wdata[NUM_CH-1:0] : '0;
    assign ovf_clr  = bus_we && bus_addr == A_OFLG && bus_wdata[0];

    // R1: the timebase steps by exactly one each clock
    p_count_step_r1: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> count == CNT_W'($past(count) + 1'b1));

    // R2: a wrap always leaves the overflow flag set
    p_wrap_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (&count) |=> ovf_flag);

    // R3: the overflow flag only drops after a write-1 clear
    p_ovf_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_flag && !ovf_clr) |=> ovf_flag);

    // R3: a clear with no wrap in the same cycle takes effect
    p_ovf_clear_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf_clr && !(&count)) |=> !ovf_flag);

    // R4: no flag rises on a channel held in compare mode
    p_cmp_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> ((cap_flag & ~$past(cap_flag) & $past(mode)) == '0));

    // R7: a capture flag falls only where a 1 was written to it
    p_flag_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> (($past(cap_flag) & ~cap_flag & ~$past(clr_mask)) == '0));
endmodule

bind cap_timer cap_timer_chk #(.NUM_CH(NUM_CH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .count     (count),
    .ovf_flag  (st_q.ovf_flag),
    .cap_flag  (st_q.cap_flag),
    .mode      (st_q.mode),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata)
);

// File: tb/sim_cap_timer.sv
module sim_cap_timer;
    import cap_timer_pkg::*;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [7:0]  cap_pin = '0;
    logic        bus_we = 1'b0;
    logic [3:0]  bus_addr = '0;
    logic [15:0] bus_wdata = '0;
    logic [15:0] bus_rdata;
    logic [7:0]  cap_irq;
    logic        ovf_irq;

    int n_run  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #5 clk = ~clk;

    cap_timer u0 (
        .clk(clk), .rst_n(rst_n), .cap_pin(cap_pin), .bus_we(bus_we),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cap_irq(cap_irq), .ovf_irq(ovf_irq)
    );

    task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
        n_run++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s: got %h expected %h", req, got, exp);
        end
    endtask

    task automatic rd(input logic [3:0] a, output logic [15:0] d);
        bus_addr = a;
        #1;
        d = bus_rdata;
    endtask

    task automatic wr(input logic [3:0] a, input logic [15:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_we    = 1'b1;
        @(negedge clk);
        bus_we    = 1'b0;
    endtask

    task automatic drive_pin(input int ch, input logic v, output logic [15:0] c);
        rd(A_COUNT, c);
        cap_pin[ch] = v;
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        logic [15:0] d;
        rd(A_COUNT, d); chk("R1 count after reset", d, 0);
        rd(A_MODE, d);  chk("R11 mode reset", d, 0);
        rd(A_EDGE, d);  chk("R11 edge reset", d, 0);
        rd(A_CFLG, d);  chk("R11 flags reset", d, 0);
        rd(A_CAP0, d);  chk("R11 cap0 reset", d, 0);
        chk("R11 irqs reset", {cap_irq, ovf_irq}, 0);
        repeat (10) @(negedge clk);
        rd(A_COUNT, d); chk("R1 count steps", d, 10);
    endtask

    task automatic t_readonly;
        logic [15:0] c, d;
        rd(A_COUNT, c);
        wr(A_COUNT, 16'h1234);
        rd(A_COUNT, d); chk("R1 count write ignored", d, 16'(c + 1));
        wr(A_CAP0 + 4'd7, 16'hBEEF);
        rd(A_CAP0 + 4'd7, d); chk("R9 capture write ignored", d, 0);
    endtask

    task automatic t_edges;
        logic [15:0] c, d;
        // ch0 rise, ch1 both, ch2 rise, ch3 fall, ch4 both, ch5 off
        wr(A_EDGE, 16'h039D);
        drive_pin(0, 1'b1, c);
        rd(A_CAP0, d); chk("R6 rising capture value", d, 16'(c + 2));
        rd(A_CFLG, d); chk("R7 flag on rise", d, 16'h0001);
        drive_pin(0, 1'b0, d);
        rd(A_CAP0, d); chk("R5 rising-only ignores fall", d, 16'(c + 2));
        wr(A_CFLG, 16'h00FF);
        rd(A_CFLG, d); chk("R7 write-1 clear", d, 0);
        drive_pin(3, 1'b1, c);
        rd(A_CFLG, d); chk("R5 falling-only ignores rise", d, 0);
        drive_pin(3, 1'b0, c);
        rd(A_CAP0 + 4'd3, d); chk("R5 falling capture", d, 16'(c + 2));
        rd(A_CFLG, d); chk("R7 flag on fall", d, 16'h0008);
        wr(A_CFLG, 16'h00FF);
        drive_pin(4, 1'b1, c);
        rd(A_CAP0 + 4'd4, d); chk("R5 both-edges rise", d, 16'(c + 2));
        wr(A_CFLG, 16'h00FF);
        drive_pin(4, 1'b0, c);
        rd(A_CAP0 + 4'd4, d); chk("R5 both-edges fall", d, 16'(c + 2));
        wr(A_CFLG, 16'h00FF);
        drive_pin(5, 1'b1, c);
        drive_pin(5, 1'b0, c);
        rd(A_CFLG, d); chk("R5 disabled channel no flag", d, 0);
        rd(A_CAP0 + 4'd5, d); chk("R5 disabled channel no capture", d, 0);
    endtask

    task automatic t_mode;
        logic [15:0] c, d;
        wr(A_MODE, 16'h0002);
        drive_pin(1, 1'b1, c);
        drive_pin(1, 1'b0, c);
        rd(A_CFLG, d); chk("R4 compare mode no flag", d, 0);
        rd(A_CAP0 + 4'd1, d); chk("R4 compare mode no capture", d, 0);
        wr(A_MODE, 16'h0000);
        drive_pin(1, 1'b1, c);
        rd(A_CAP0 + 4'd1, d); chk("R4 capture mode captures", d, 16'(c + 2));
        wr(A_CFLG, 16'h00FF);
    endtask

    task automatic t_overwrite;
        logic [15:0] c1, c2, d;
        drive_pin(0, 1'b1, c1);
        drive_pin(0, 1'b0, d);
        drive_pin(0, 1'b1, c2);
        rd(A_CAP0, d); chk("R8 pending flag overwrite", d, 16'(c2 + 2));
        rd(A_CFLG, d); chk("R8 flag still set", d, 16'h0001);
        wr(A_CFLG, 16'h0000);
        rd(A_CFLG, d); chk("R7 write-0 no effect", d, 16'h0001);
        wr(A_CFLG, 16'h00FF);
    endtask

    task automatic t_collide;
        logic [15:0] c, d;
        drive_pin(2, 1'b1, d);
        drive_pin(2, 1'b0, d);
        rd(A_COUNT, c);
        cap_pin[2] = 1'b1;
        repeat (2) @(negedge clk);
        wr(A_CFLG, 16'h0004);   // lands on the capture edge
        repeat (2) @(negedge clk);
        rd(A_CFLG, d); chk("R7 capture beats clear", d, 16'h0004);
        rd(A_CAP0 + 4'd2, d); chk("R6 capture in collision", d, 16'(c + 2));
        wr(A_CFLG, 16'h0004);
        rd(A_CFLG, d); chk("R7 clear after collision", d, 0);
    endtask

    task automatic t_irq;
        logic [15:0] d;
        drive_pin(2, 1'b0, d);
        drive_pin(2, 1'b1, d);
        chk("R10 irq masked", cap_irq, 0);
        wr(A_IEN, 16'h0004);
        chk("R10 irq enabled", cap_irq, 8'h04);
        wr(A_CFLG, 16'h0004);
        chk("R10 irq drops on clear", cap_irq, 0);
    endtask

    task automatic t_ovf;
        logic [15:0] c, d;
        rd(A_COUNT, c);
        repeat (16'hFFFF - c) @(negedge clk);
        rd(A_COUNT, d); chk("R2 count at max", d, 16'hFFFF);
        rd(A_OFLG, d);  chk("R2 no flag before wrap", d, 0);
        @(negedge clk);
        rd(A_COUNT, d); chk("R2 count wrapped", d, 0);
        rd(A_OFLG, d);  chk("R2 flag after wrap", d, 1);
        chk("R10 ovf irq masked", ovf_irq, 0);
        wr(A_OFLG, 16'h0000);
        rd(A_OFLG, d);  chk("R3 write-0 keeps flag", d, 1);
        wr(A_OEN, 16'h0001);
        chk("R10 ovf irq enabled", ovf_irq, 1);
        wr(A_OFLG, 16'h0001);
        rd(A_OFLG, d);  chk("R3 write-1 clears", d, 0);
        chk("R10 ovf irq cleared", ovf_irq, 0);
        rd(A_COUNT, c);
        repeat (16'hFFFF - c) @(negedge clk);
        rd(A_COUNT, d); chk("R3 count at max again", d, 16'hFFFF);
        wr(A_OFLG, 16'h0001);   // clear on the wrap edge
        rd(A_OFLG, d);  chk("R3 wrap beats clear", d, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_readonly();
        t_edges();
        t_mode();
        t_overwrite();
        t_collide();
        t_irq();
        t_ovf();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_run++;
            n_fail++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end
endmodule